// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM in which reads and writes may be mixed freely on every clock, with no idle cycle when the bus changes direction. Each operation is presented as an address plus control on one rising edge. Its data moves one cycle later. For a read, the data appears on `rd_data` during the following cycle. For a write, the data is taken from `wr_data` at the next enabled edge. Because a write's data trails its address by a cycle, the address bus and the data bus are both busy on every cycle of an alternating read/write stream.

Operations start only when all three chip enables are active and the load strobe is low. With the load strobe high, an operation already running continues as a four-beat burst. The low two address bits step in linear or interleaved order, chosen by the `burst_linear` input. An active-low clock enable freezes the whole block. Captured write data waits in a one-entry pending slot and is committed to the array on the next enabled edge. A read that targets the pending address picks up the waiting bytes per lane. The output enable acts without a clock. A pad would use `rd_drive` as its drive control. `rd_data` is all zeros whenever the drive is off.

Top module: `zbt_sram`

## Requirements
- R1: A read started on enabled edge k (ld_n=0, ce1_n=0, ce2=1, ce3_n=0, we_n=1) sets rd_drive high during the cycle after edge k while oe_n is low. In that cycle rd_data carries the word stored at the addressed location.
- R2: A write started on enabled edge k takes its data from wr_data at the next enabled edge. A later read of that address returns it. Reads and writes may alternate on consecutive edges with no idle cycle.
- R3: Lane i of a word occupies bits 9i+8 down to 9i. A write changes lane i only if bw_n[i] was low on its address edge. A write with bw_n all ones leaves the stored word unchanged.
- R4: If a read is started on the edge that captures a write's data to the same address, it returns that write's bytes in the enabled lanes and the earlier contents in the other lanes.
- R5: While clk_en_n is high, no input is acted on and no register changes. rd_drive and rd_data keep their values, and a write attempted during the hold does not reach memory.
- R6: If ld_n is low on an enabled edge and any one of ce1_n=1, ce2=0 or ce3_n=1 holds, no operation starts and rd_drive is low in the following cycle. Any burst in progress stops, so a later ld_n=1 edge starts nothing.
- R7: A write whose address edge is followed directly by a deselect edge still stores the data presented on that deselect edge.
- R8: An edge with ld_n=1 during a running burst repeats the operation type at the next burst address. The upper address bits stay fixed and the low two bits are base+n mod 4 when burst_linear=1, or base XOR n when burst_linear=0, for n = 0..3 and wrapping after that.
- R9: rd_drive is low in the cycle after a write is started or after a deselect. Driving oe_n high forces rd_drive low and rd_data to zero at once, with no clock edge.
- R10: After reset no operation or write is pending, and rd_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| ld_n | input | 1 | Low: load a new operation; high: advance the burst |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low selects write, high selects read |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_linear | input | 1 | 1: linear burst order, 0: interleaved |
| wr_data | input | LANES*LANE_W | Write data, sampled one cycle after its address |
| rd_data | output | LANES*LANE_W | Read data, zero while not driving |
| rd_drive | output | 1 | High while the read data bus would be driven |

## Verification
A corrupt operation register, such as a lost read flag or a wrong burst offset, shows up at the ports in the very next cycle: `rd_drive` is wrong, or `rd_data` holds a neighbouring word of the four-word group. A wrong pending-write slot shows up only later, on the read of that address, either immediately through the lane merge or after the slot commits. For that reason each write is read back both on the next cycle and after several idle cycles. A clock enable that leaks would move the output during a hold, or would let a write made during the hold appear on the next read.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int unsigned ZBT_LANE_W = 9;
  localparam int unsigned ZBT_LANES  = 4;
  localparam int unsigned ZBT_AW     = 6;
  localparam int unsigned ZBT_BB     = 2;

  // All three chip enables must be in their active state.
  function automatic logic zbt_selected(input logic c1_n, input logic c2,
                                        input logic c3_n);
    return (!c1_n) && c2 && (!c3_n);
  endfunction

endpackage

// File: rtl/zbt_rst_sync.sv
module zbt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr #(
  parameter int unsigned BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          adv,
  input  logic          linear,
  input  logic [BB-1:0] base_lsb,
  output logic [BB-1:0] lsb
);

  logic [BB-1:0] cnt_q;
  logic [BB-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (load) begin
        cnt_d = '0;
      end else if (adv) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Order is chosen combinationally from the stored offset.
  assign lsb = linear ? (base_lsb + cnt_q) : (base_lsb ^ cnt_q);

endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int unsigned AW    = ZBT_AW,
  parameter int unsigned LANES = ZBT_LANES,
  parameter int unsigned BB    = ZBT_BB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             ld_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             burst_linear,
  output logic             act_q,
  output logic             wr_q,
  output logic [AW-1:0]    op_addr,
  output logic [LANES-1:0] op_be
);

  logic             en;
  logic             sel;
  logic             start;
  logic             cont;
  logic             act_d;
  logic             wr_d;
  logic             bon_q;
  logic             bon_d;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    base_d;
  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_d;
  logic [BB-1:0]    lsb;

  assign en    = !clk_en_n;
  assign sel   = zbt_selected(ce1_n, ce2, ce3_n);
  assign start = (!ld_n) && sel;
  assign cont  = ld_n && bon_q;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    bon_d  = bon_q;
    base_d = base_q;
    be_d   = be_q;
    if (en) begin
      be_d = ~bw_n;
      if (!ld_n) begin
        act_d = sel;
        wr_d  = sel && !we_n;
        bon_d = sel;
        if (sel) begin
          base_d = addr;
        end
      end else begin
        act_d = bon_q;
        wr_d  = bon_q && wr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      bon_q <= 1'b0;
    end else begin
      act_q <= act_d;
      wr_q  <= wr_d;
      bon_q <= bon_d;
    end
  end

  always_ff @(posedge clk) begin
    base_q <= base_d;
    be_q   <= be_d;
  end

  zbt_burst_ctr #(.BB(BB)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (start),
    .adv      (cont),
    .linear   (burst_linear),
    .base_lsb (base_q[BB-1:0]),
    .lsb      (lsb)
  );

  assign op_addr = {base_q[AW-1:BB], lsb};
  assign op_be   = be_q;

endmodule

// File: rtl/zbt_array.sv
module zbt_array
  import zbt_pkg::*;
#(
  parameter int unsigned AW     = ZBT_AW,
  parameter int unsigned LANES  = ZBT_LANES,
  parameter int unsigned LANE_W = ZBT_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    cap,
  input  logic [AW-1:0]           cap_addr,
  input  logic [LANES-1:0]        cap_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned W     = LANES * LANE_W;

  logic             pw_v_q;
  logic             pw_v_d;
  logic [AW-1:0]    pw_a_q;
  logic [AW-1:0]    pw_a_d;
  logic [LANES-1:0] pw_be_q;
  logic [LANES-1:0] pw_be_d;
  logic [W-1:0]     pw_d_q;
  logic [W-1:0]     pw_d_d;
  logic             commit;
  logic             hit;

  always_comb begin
    pw_v_d  = pw_v_q;
    pw_a_d  = pw_a_q;
    pw_be_d = pw_be_q;
    pw_d_d  = pw_d_q;
    if (en) begin
      pw_v_d = cap;
      if (cap) begin
        pw_a_d  = cap_addr;
        pw_be_d = cap_be;
        pw_d_d  = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_v_q <= 1'b0;
    end else begin
      pw_v_q <= pw_v_d;
    end
  end

  always_ff @(posedge clk) begin
    pw_a_q  <= pw_a_d;
    pw_be_q <= pw_be_d;
    pw_d_q  <= pw_d_d;
  end

  assign commit = en && pw_v_q;
  assign hit    = pw_v_q && (pw_a_q == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && pw_be_q[g]) begin
        mem_l[pw_a_q] <= pw_d_q[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = (hit && pw_be_q[g])
                                         ? pw_d_q[g*LANE_W +: LANE_W]
                                         : mem_l[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned AW     = ZBT_AW,
  parameter int unsigned LANES  = ZBT_LANES,
  parameter int unsigned LANE_W = ZBT_LANE_W,
  parameter int unsigned BB     = ZBT_BB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    ld_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [AW-1:0]           addr,
  input  logic                    oe_n,
  input  logic                    burst_linear,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);

  localparam int unsigned W = LANES * LANE_W;

  logic             rst_sync_n;
  logic             act_q;
  logic             wr_q;
  logic [AW-1:0]    op_addr;
  logic [LANES-1:0] op_be;
  logic [W-1:0]     rd_word;

  zbt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  zbt_ctrl #(.AW(AW), .LANES(LANES), .BB(BB)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clk_en_n     (clk_en_n),
    .ld_n         (ld_n),
    .ce1_n        (ce1_n),
    .ce2          (ce2),
    .ce3_n        (ce3_n),
    .we_n         (we_n),
    .bw_n         (bw_n),
    .addr         (addr),
    .burst_linear (burst_linear),
    .act_q        (act_q),
    .wr_q         (wr_q),
    .op_addr      (op_addr),
    .op_be        (op_be)
  );

  zbt_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (!clk_en_n),
    .cap      (act_q && wr_q),
    .cap_addr (op_addr),
    .cap_be   (op_be),
    .wr_data  (wr_data),
    .rd_addr  (op_addr),
    .rd_word  (rd_word)
  );

  assign rd_drive = (!oe_n) && act_q && (!wr_q);
  assign rd_data  = rd_drive ? rd_word : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_en_n,
  input logic         ld_n,
  input logic         ce1_n,
  input logic         ce2,
  input logic         ce3_n,
  input logic         we_n,
  input logic         oe_n,
  input logic         act_q,
  input logic         wr_q,
  input logic         rd_drive,
  input logic [W-1:0] rd_data
);

  logic chip_on;
  assign chip_on = (!ce1_n) && ce2 && (!ce3_n);

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && chip_on && we_n) |=> (oe_n || rd_drive)); // R1

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(act_q) && $stable(wr_q))); // R5

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && !chip_on) |=> !rd_drive); // R6

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && chip_on && !we_n) |=> !rd_drive); // R9

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rd_drive && (rd_data == '0))); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!rd_drive && !act_q)); // R10

endmodule

bind zbt_sram zbt_sram_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .clk_en_n (clk_en_n),
  .ld_n     (ld_n),
  .ce1_n    (ce1_n),
  .ce2      (ce2),
  .ce3_n    (ce3_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .act_q    (act_q),
  .wr_q     (wr_q),
  .rd_drive (rd_drive),
  .rd_data  (rd_data)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int W  = LN * LW;

  localparam int K_RD   = 0;
  localparam int K_WR   = 1;
  localparam int K_ADV  = 2;
  localparam int K_DES  = 3;
  localparam int K_DES2 = 4;
  localparam int K_DES3 = 5;
  localparam int K_SUSP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          ld_n = 1'b0;
  logic          ce1_n = 1'b1;
  logic          ce2 = 1'b1;
  logic          ce3_n = 1'b0;
  logic          we_n = 1'b1;
  logic [LN-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic          burst_linear = 1'b1;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic          rd_drive;

  logic [W-1:0]  s_data;
  logic          s_drv;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  zbt_sram #(.AW(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en_n     (clk_en_n),
    .ld_n         (ld_n),
    .ce1_n        (ce1_n),
    .ce2          (ce2),
    .ce3_n        (ce3_n),
    .we_n         (we_n),
    .bw_n         (bw_n),
    .addr         (addr),
    .oe_n         (oe_n),
    .burst_linear (burst_linear),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .rd_drive     (rd_drive)
  );

  task automatic chk_w(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_b(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Samples the outputs of the previous operation, then drives the next one.
  task automatic step(input int kind, input logic [AW-1:0] a,
                      input logic [LN-1:0] bw, input logic [W-1:0] wd);
    @(negedge clk);
    s_data   = rd_data;
    s_drv    = rd_drive;
    clk_en_n = (kind == K_SUSP);
    ld_n     = (kind == K_ADV);
    ce1_n    = (kind == K_DES);
    ce2      = (kind != K_DES2);
    ce3_n    = (kind == K_DES3);
    we_n     = !((kind == K_WR) || (kind == K_SUSP));
    bw_n     = bw;
    addr     = a;
    wr_data  = wd;
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_w,
                                         input logic [W-1:0] new_w,
                                         input logic [LN-1:0] bwn);
    logic [W-1:0] r;
    r = old_w;
    for (int i = 0; i < LN; i++) begin
      if (!bwn[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    end
    return r;
  endfunction

  localparam logic [W-1:0] D5 = 36'h1_2345_6789;
  localparam logic [W-1:0] DA = 36'hA_BCDE_F012;
  localparam logic [W-1:0] DB = 36'h5_5AA5_3C3C;
  localparam logic [W-1:0] DF = 36'hF_0F0F_0F0F;
  localparam logic [W-1:0] DG = 36'h3_1415_9265;
  localparam logic [W-1:0] DH = 36'hE_EEEE_EEEE;
  localparam logic [W-1:0] DQ = 36'h7_7777_0000;
  localparam logic [W-1:0] DP = 36'h8_1234_8765;
  localparam logic [W-1:0] DR = 36'h2_7182_8182;
  localparam logic [W-1:0] DS = 36'h9_ABAB_CDCD;
  localparam logic [W-1:0] DJ = 36'hD_EAD0_BEEF;

  task automatic t_reset();
    @(negedge clk);
    chk_b("R10 drive after reset", rd_drive, 1'b0);
    chk_w("R10 data after reset", rd_data, '0);
  endtask

  task automatic t_basic();
    step(K_WR, 6'd5, '0, '0);
    step(K_DES, 6'd0, '1, D5);
    chk_b("R9 drive after write start", s_drv, 1'b0);
    step(K_RD, 6'd5, '1, '0);
    step(K_DES, 6'd0, '1, '0);
    chk_b("R1 read drive", s_drv, 1'b1);
    chk_w("R7 write before deselect stored", s_data, D5);
    // Alternating writes and reads on consecutive edges.
    step(K_WR, 6'd1, '0, '0);
    step(K_RD, 6'd5, '1, DA);
    step(K_WR, 6'd2, '0, '0);
    chk_w("R2 read between writes", s_data, D5);
    step(K_RD, 6'd1, '1, DB);
    chk_b("R9 drive off in write cycle", s_drv, 1'b0);
    step(K_RD, 6'd2, '1, '0);
    chk_w("R2 alternating read addr1", s_data, DA);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R2 alternating read addr2", s_data, DB);
  endtask

  task automatic t_lanes();
    step(K_WR, 6'd7, '0, '0);
    step(K_DES, 6'd0, '1, DF);
    step(K_WR, 6'd7, 4'b1010, '0);
    step(K_DES, 6'd0, '1, DG);
    step(K_WR, 6'd7, 4'b1111, '0);
    step(K_DES, 6'd0, '1, DH);
    step(K_DES, 6'd0, '1, '0);
    step(K_RD, 6'd7, '1, '0);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R3 lane merge and masked write", s_data, merge(DF, DG, 4'b1010));
  endtask

  task automatic t_fwd();
    step(K_WR, 6'd9, '0, '0);
    step(K_DES, 6'd0, '1, DQ);
    step(K_WR, 6'd9, 4'b1001, '0);
    step(K_RD, 6'd9, '1, DP);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R4 forward partial", s_data, merge(DQ, DP, 4'b1001));
    step(K_WR, 6'd10, '0, '0);
    step(K_RD, 6'd10, '1, DR);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R4 forward full", s_data, DR);
  endtask

  task automatic t_susp();
    step(K_RD, 6'd5, '1, '0);
    step(K_SUSP, 6'd5, '0, DJ);
    chk_w("R5 read before hold", s_data, D5);
    step(K_SUSP, 6'd5, '0, DJ);
    chk_b("R5 drive held", s_drv, 1'b1);
    chk_w("R5 data held", s_data, D5);
    step(K_RD, 6'd5, '1, '0);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R5 write during hold ignored", s_data, D5);
    // Write data capture waits across a hold.
    step(K_WR, 6'd11, '0, '0);
    step(K_SUSP, 6'd11, '0, DJ);
    step(K_SUSP, 6'd11, '0, DJ);
    step(K_DES, 6'd0, '1, DS);
    step(K_RD, 6'd11, '1, '0);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R5 write data taken after hold", s_data, DS);
  endtask

  task automatic t_desel(input int kind, input string tag);
    step(K_RD, 6'd5, '1, '0);
    step(kind, 6'd5, '1, '0);
    chk_b({"R6 read before ", tag}, s_drv, 1'b1);
    step(K_ADV, 6'd5, '1, '0);
    chk_b({"R6 deselect ", tag}, s_drv, 1'b0);
    step(K_DES, 6'd0, '1, '0);
    chk_b({"R6 burst stopped ", tag}, s_drv, 1'b0);
  endtask

  task automatic t_burst();
    logic [W-1:0] wv [4];
    for (int i = 0; i < 4; i++) wv[i] = 36'h1_0000_0000 * (i + 1) + 36'h111 * (i + 3);
    burst_linear = 1'b1;
    step(K_WR, 6'd16, '0, '0);
    step(K_ADV, 6'd0, '0, wv[0]);
    step(K_ADV, 6'd0, '0, wv[1]);
    step(K_ADV, 6'd0, '0, wv[2]);
    step(K_DES, 6'd0, '1, wv[3]);
    // Linear read from offset 1: 1,2,3,0.
    step(K_RD, 6'd17, '1, '0);
    step(K_ADV, 6'd0, '1, '0);
    chk_w("R8 linear beat0", s_data, wv[1]);
    step(K_ADV, 6'd0, '1, '0);
    chk_w("R8 linear beat1", s_data, wv[2]);
    step(K_ADV, 6'd0, '1, '0);
    chk_w("R8 linear beat2", s_data, wv[3]);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R8 linear beat3 wrap", s_data, wv[0]);
    // Interleaved read from offset 1: 1,0,3,2.
    burst_linear = 1'b0;
    step(K_RD, 6'd17, '1, '0);
    step(K_ADV, 6'd0, '1, '0);
    chk_w("R8 interleaved beat0", s_data, wv[1]);
    step(K_ADV, 6'd0, '1, '0);
    chk_w("R8 interleaved beat1", s_data, wv[0]);
    step(K_ADV, 6'd0, '1, '0);
    chk_w("R8 interleaved beat2", s_data, wv[3]);
    step(K_DES, 6'd0, '1, '0);
    chk_w("R8 interleaved beat3", s_data, wv[2]);
    burst_linear = 1'b1;
  endtask

  task automatic t_oe();
    step(K_RD, 6'd5, '1, '0);
    step(K_DES, 6'd0, '1, '0);
    oe_n = 1'b1;
    #1;
    chk_b("R9 oe off drive", rd_drive, 1'b0);
    chk_w("R9 oe off data", rd_data, '0);
    oe_n = 1'b0;
    #1;
    chk_b("R9 oe on drive", rd_drive, 1'b1);
    chk_w("R9 oe on data", rd_data, D5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_lanes();
    t_fwd();
    t_susp();
    t_desel(K_DES, "ce1");
    t_desel(K_DES2, "ce2");
    t_desel(K_DES3, "ce3");
    t_burst();
    t_oe();
    step(K_DES, 6'd0, '1, '0);
    finish_run();
  end

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

endmodule